// File: doc/BRIEF.md
# Two-Wire Block-Transfer Control Register Slave

This block is a slave-only endpoint on a two-wire serial bus (SMBus-style open-drain clock and data). It holds three byte-wide control registers for a clock fan-out stage and presents their fields as decoded control pins. These are: an input divider select, a loop bypass select, a loop bandwidth select, two tri-state policy bits, one enable per output, and one free-run flag per output. The block never drives the clock line, and it only ever pulls the data line low.

Only block transfers with an index are understood. A write carries the device address, a starting register index, a non-zero byte count and then the data bytes. A read sets the index with a short write and then uses a repeated START with the read bit. The slave answers with a byte count and then the register bytes from that index onward. Both bus lines pass through synchronizers into the system clock domain. START and STOP are taken to be data-line edges seen while the clock line is high.

Top module: `smb_ctrl_slave`

## Requirements
- R1: After reset, register 0 reads 8'h03, register 1 reads all ones and register 2 reads all zeros. The decoded pins follow from these values, and sda_pull is 0.
- R2: Only the 7-bit address 7'h6E (address byte {addr, r/w}, r/w = 1 for read) is acknowledged. Any other address is not acknowledged, and no register changes.
- R3: In a write, the byte after the address is the starting index and the next byte is the count. Each of the count data bytes is acknowledged and lands in register index, index+1, and so on.
- R4: A byte count of zero is not acknowledged. Data bytes sent after it are not acknowledged, and no register is written.
- R5: Data bytes addressed at an index of 3 or more are acknowledged and discarded.
- R6: Bits 7:5 of register 0 are reserved. They read as 0 and ignore writes.
- R7: A read returns the count byte 8'h03 first. It then returns the register bytes from the index onward, most significant bit first. Indices of 3 or more return 8'h00.
- R8: When the master does not acknowledge a read byte, the slave releases the data line (sda_pull = 0) and keeps it released until the next START.
- R9: Register 0 decodes as follows: bit0 = 1 selects an undivided input (div_normal), bit1 = 1 selects the loop (pll_on), bit2 = 1 selects low bandwidth, bit3 = 1 tri-states on stop and bit4 = 1 tri-states on power-down. Register 1 bit n drives out_en[n], and register 2 bit n drives free_run[n].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls the data line low |
| div_normal | output | 1 | 1 = undivided input clock, 0 = divide by two |
| pll_on | output | 1 | 1 = loop path, 0 = direct fan-out |
| bw_low | output | 1 | 1 = low loop bandwidth |
| stop_tri | output | 1 | 1 = outputs float when stopped |
| pd_tri | output | 1 | 1 = outputs float when powered down |
| out_en | output | NUM_OUT | Per-output enable |
| free_run | output | NUM_OUT | Per-output free-run flag |

## Verification
The assertions assume that the master changes the data line only while the clock line is low, except for START and STOP. They also assume that each clock phase lasts several system clocks longer than the synchronizer delay, so the slave's own pull changes always land in a low clock phase. The bench drives bits with eight-cycle half periods and moves data two cycles after each falling clock edge, which keeps it inside these assumptions. It checks acknowledge bits, read data and the decoded pins against a behavioural register model on every clock outside a write byte in progress.

// File: rtl/smb_ctrl_pkg.sv
package smb_ctrl_pkg;
  localparam int NUM_REGS = 3;
  localparam int IDX_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } bus_state_e;

  typedef enum logic [1:0] {
    SG_ADDR, SG_OFFS, SG_CNT, SG_DATA
  } stage_e;

  function automatic logic [7:0] lane_mask(input int n);
    int v;
    v = (1 << n) - 1;
    return v[7:0];
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d[b]};
    end
    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import smb_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

  bus_state_e       state_q, state_n;
  stage_e           stage_q, stage_n;
  logic [3:0]       bit_q, bit_n;
  logic [7:0]       sh_q, sh_n;
  logic [IDX_W-1:0] ptr_q, ptr_n;
  logic [7:0]       left_q, left_n;
  logic             rnw_q, rnw_n, mack_q, mack_n, pull_q, pull_n;

  always_comb begin
    state_n = state_q; stage_n = stage_q; bit_n = bit_q; sh_n = sh_q;
    ptr_n = ptr_q; left_n = left_q; rnw_n = rnw_q; mack_n = mack_q;
    pull_n = pull_q; wr_en = 1'b0;
    if (start_det) begin
      state_n = ST_RX; stage_n = SG_ADDR; bit_n = '0; pull_n = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE; pull_n = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_s};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_n = '0; state_n = ST_RX_ACK; pull_n = 1'b1;
            unique case (stage_q)
              SG_ADDR: begin
                if (sh_q[7:1] != DEV_ADDR) begin
                  state_n = ST_IDLE; pull_n = 1'b0;
                end else begin
                  rnw_n = sh_q[0]; stage_n = SG_OFFS;
                end
              end
              SG_OFFS: begin ptr_n = sh_q; stage_n = SG_CNT; end
              SG_CNT: begin
                if (sh_q == 8'd0) begin
                  state_n = ST_IDLE; pull_n = 1'b0;
                end else begin
                  left_n = sh_q; stage_n = SG_DATA;
                end
              end
              SG_DATA: begin
                if (left_q == 8'd0) begin
                  state_n = ST_IDLE; pull_n = 1'b0;
                end else begin
                  left_n = left_q - 8'd1;
                  ptr_n  = ptr_q + 1'b1;
                  wr_en  = (ptr_q < IDX_W'(NUM_REGS));
                end
              end
              default: ;
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bit_n = '0;
            if (rnw_q) begin
              state_n = ST_TX; sh_n = CNT_BYTE; pull_n = ~CNT_BYTE[7];
            end else begin
              state_n = ST_RX; pull_n = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              pull_n = 1'b0; state_n = ST_TX_ACK;
            end else begin
              sh_n = {sh_q[6:0], 1'b0}; pull_n = ~sh_q[6]; bit_n = bit_q + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_n = ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              sh_n = rd_data; ptr_n = ptr_q + 1'b1; pull_n = ~rd_data[7];
              state_n = ST_TX; bit_n = '0;
            end else begin
              state_n = ST_IDLE; pull_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; stage_q <= SG_ADDR; bit_q <= '0; sh_q <= '0;
      ptr_q <= '0; left_q <= '0; rnw_q <= 1'b0; mack_q <= 1'b0; pull_q <= 1'b0;
    end else begin
      state_q <= state_n; stage_q <= stage_n; bit_q <= bit_n; sh_q <= sh_n;
      ptr_q <= ptr_n; left_q <= left_n; rnw_q <= rnw_n; mack_q <= mack_n;
      pull_q <= pull_n;
    end
  end

  assign idx      = ptr_q;
  assign wr_data  = sh_q;
  assign sda_pull = pull_q;

  // Pull changes only in a low clock phase (acknowledge and read bits).
  p_pull_on_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_s));
  p_release_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));
  // Every stored data byte is acknowledged.
  p_write_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_pull);
  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_pull);
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_ctrl_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic [NUM_REGS-1:0][7:0] regs
);
  localparam logic [7:0] LANE_M = lane_mask(NUM_OUT);

  function automatic logic [7:0] rst_val(input int i);
    return (i == 0) ? 8'h03 : (i == 1) ? LANE_M : 8'h00;
  endfunction
  function automatic logic [7:0] wmask(input int i);
    return (i == 0) ? 8'h1F : LANE_M;
  endfunction

  logic [NUM_REGS-1:0][7:0] regs_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[i] <= rst_val(i);
      else if (hit) regs_q[i] <= wr_data & wmask(i);
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rd_data = regs_q[i];
  end

  assign regs = regs_q;

  // Discarded indices never reach the bank as a write.
  p_idx_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (idx < IDX_W'(NUM_REGS)));
  p_hold_without_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/smb_ctrl_slave.sv
module smb_ctrl_slave
  import smb_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6E,
  parameter int         NUM_OUT     = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  output logic               div_normal,
  output logic               pll_on,
  output logic               bw_low,
  output logic               stop_tri,
  output logic               pd_tri,
  output logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] free_run
);
  logic [1:0]       line_s;
  logic             scl_rise, scl_fall, start_det, stop_det, wr_en;
  logic [IDX_W-1:0] idx;
  logic [7:0]       wr_data, rd_data;
  logic [NUM_REGS-1:0][7:0] regs;

  smb_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s));

  smb_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  smb_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .idx(idx), .wr_en(wr_en), .wr_data(wr_data), .sda_pull(sda_pull));

  smb_reg_bank #(.NUM_OUT(NUM_OUT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx),
    .wr_data(wr_data), .rd_data(rd_data), .regs(regs));

  assign div_normal = regs[0][0];
  assign pll_on     = regs[0][1];
  assign bw_low     = regs[0][2];
  assign stop_tri   = regs[0][3];
  assign pd_tri     = regs[0][4];
  assign out_en     = regs[1][NUM_OUT-1:0];
  assign free_run   = regs[2][NUM_OUT-1:0];
endmodule

// File: tb/test_smb_ctrl_slave.sv
module test_smb_ctrl_slave;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, div_normal, pll_on, bw_low, stop_tri, pd_tri;
  logic [7:0] out_en, free_run;
  wire sda_bus = sda_m & ~sda_pull;

  smb_ctrl_slave i_smb_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .div_normal(div_normal), .pll_on(pll_on),
    .bw_low(bw_low), .stop_tri(stop_tri), .pd_tri(pd_tri),
    .out_en(out_en), .free_run(free_run));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0, in_flight = 1'b1;
  logic [7:0] mdl [3];
  logic [7:0] msk [3];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [20:0] pins_now();
    return {div_normal, pll_on, bw_low, stop_tri, pd_tri, out_en, free_run};
  endfunction
  function automatic logic [20:0] pins_mdl();
    return {mdl[0][0], mdl[0][1], mdl[0][2], mdl[0][3], mdl[0][4], mdl[1], mdl[2]};
  endfunction

  // Model versus pins on every clock outside a write byte (R9 decode).
  always @(negedge clk)
    if (rst_n && !in_flight && !done)
      check(pins_now() == pins_mdl(), "R9 per-clock pins", 32'(pins_now()), 32'(pins_mdl()));

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(output logic s);
    wt(H); scl_m = 1'b1; wt(H/2); s = sda_bus; wt(H/2); scl_m = 1'b0; wt(2);
  endtask
  task automatic bus_start(); sda_m = 1'b1; wt(2); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(2); endtask
  task automatic bus_stop(); sda_m = 1'b0; wt(2); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H); endtask
  task automatic send(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin sda_m = b[i]; pulse(s); end
    sda_m = 1'b1; pulse(s); ack = !s;
  endtask
  task automatic recv(input bit mack, output logic [7:0] b);
    logic s;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin pulse(s); b = {b[6:0], s}; end
    sda_m = !mack; pulse(s); sda_m = 1'b1;
  endtask

  // Block write; cnt bytes taken from data; model updated per acked byte.
  task automatic blk_write(input logic [6:0] a, input logic [7:0] off, input logic [7:0] cnt,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    bit ack;
    logic [7:0] d [3];
    int n;
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send({a, 1'b0}, ack);
    check(ack == (a == 7'h6E), "R2 address ack", 32'(ack), 32'(a == 7'h6E));
    if (a == 7'h6E) begin
      send(off, ack); check(ack, "R3 index ack", 32'(ack), 1);
      send(cnt, ack); check(ack == (cnt != 0), "R4 count ack", 32'(ack), 32'(cnt != 0));
      n = (cnt == 0) ? 1 : int'(cnt);
      for (int i = 0; i < n; i++) begin
        in_flight = 1'b1;
        send(d[i], ack);
        check(ack == (cnt != 0), (off + i >= 3) ? "R5 data ack" : "R3 data ack", 32'(ack), 32'(cnt != 0));
        if (ack && (off + i < 3)) mdl[off + i] = d[i] & msk[off + i];
        in_flight = 1'b0;
      end
    end
    bus_stop();
  endtask

  task automatic blk_read(input logic [7:0] off, input int n);
    bit ack;
    logic [7:0] b;
    bus_start();
    send({7'h6E, 1'b0}, ack); check(ack, "R7 address ack", 32'(ack), 1);
    send(off, ack);           check(ack, "R7 index ack", 32'(ack), 1);
    bus_start();
    send({7'h6E, 1'b1}, ack); check(ack, "R7 read address ack", 32'(ack), 1);
    recv(1'b1, b);            check(b == 8'h03, "R7 count byte", 32'(b), 32'h03);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      check(b == ((off + i < 3) ? mdl[off + i] : 8'h00), "R7 read byte", 32'(b),
            32'((off + i < 3) ? mdl[off + i] : 8'h00));
    end
    for (int i = 0; i < 3 * H; i++) begin
      wt(1); check(sda_pull == 1'b0, "R8 released after master NACK", 32'(sda_pull), 0);
      if (i == H) scl_m = 1'b1;
      if (i == 2 * H) scl_m = 1'b0;
    end
    bus_stop();
  endtask

  initial begin
    mdl[0] = 8'h03; mdl[1] = 8'hFF; mdl[2] = 8'h00;
    msk[0] = 8'h1F; msk[1] = 8'hFF; msk[2] = 8'hFF;
    wt(4); rst_n = 1'b1; wt(2); in_flight = 1'b0;
    check(pins_now() == {5'b11000, 8'hFF, 8'h00}, "R1 reset pins", 32'(pins_now()), 32'({5'b11000, 8'hFF, 8'h00}));
    check(sda_pull == 1'b0, "R1 reset pull", 32'(sda_pull), 0);
    blk_write(7'h2A, 8'd0, 8'd1, 8'h00, 8'h00, 8'h00);          // R2 wrong address
    check(pins_now() == pins_mdl(), "R2 no change", 32'(pins_now()), 32'(pins_mdl()));
    blk_write(7'h6E, 8'd0, 8'd3, 8'hFF, 8'h5A, 8'hC3);           // R3, R6
    blk_read(8'd0, 3);                                           // R7, R6 reserved zero
    blk_write(7'h6E, 8'd1, 8'd0, 8'h00, 8'h00, 8'h00);           // R4 zero count
    check(out_en == 8'h5A, "R4 register 1 untouched", 32'(out_en), 32'h5A);
    blk_write(7'h6E, 8'd2, 8'd3, 8'h11, 8'h22, 8'h33);           // R5 overflow
    check(free_run == 8'h11, "R5 last register only", 32'(free_run), 32'h11);
    blk_read(8'd1, 4);                                           // R7 beyond end, R8
    blk_write(7'h6E, 8'd0, 8'd1, 8'hF5, 8'h00, 8'h00);           // R9 decode, R6
    check({div_normal, pll_on, bw_low, stop_tri, pd_tri} == 5'b10101, "R9 field decode",
          32'({div_normal, pll_on, bw_low, stop_tri, pd_tri}), 32'b10101);
    blk_read(8'd0, 1);                                           // R6 reads 8'h15, R8
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1; failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule